// File: doc/BRIEF.md
# Direct Digital Synthesis Waveform Core

The core is a numerically controlled oscillator. It produces a 10-bit unsigned sample stream and a one-bit square/clock signal from a single master clock. Two frequency tuning words and two phase offset words are held in on-chip registers. Each register is written through its own parallel load strobe. Two select inputs choose which tuning word and which offset word are active.

On every master clock a 28-bit phase accumulator advances by the active tuning word, so the output frequency is f_clk × word / 2^28. The active 12-bit offset is added to the accumulator's top 12 bits to form the phase. The phase is converted to a sample in one of three ways: through a quarter-wave sine table, by folding into a triangle, or as a full-scale square. The most significant phase bit also drives the square/clock pin, either directly or through a divide-by-two toggle. A sleep input freezes the core. A synchronous reset restarts the phase without losing the programmed words.

Top module: `dds_wavegen`

## Requirements
- R1: On each clock edge with rst and sleep low, the accumulator becomes (acc + selected word) mod 2^28, where fsel=0 selects freq word 0 and fsel=1 selects freq word 1. A change of fsel only changes the increment used; the accumulator is not cleared.
- R2: A load strobe (ld_f0, ld_f1, ld_p0, ld_p1) copies fword or pword into its register at that clock edge. The new value is first used at the following edge. Loads are accepted during rst and sleep, and registers hold their value otherwise.
- R3: Phase ph = (acc[27:16] + selected offset) mod 2^12, where psel=0 selects offset 0 and psel=1 selects offset 1.
- R4: With mode=00 (sine), let idx = ph[10] ? ~ph[9:2] : ph[9:2] and q = floor(511·4·idx·(512−idx) / (327680 − idx·(512−idx))). The sample is 512+q when ph[11]=0 and 511−q when ph[11]=1.
- R5: With mode=01 (triangle), the sample is ph[10:1] when ph[11]=0 and the bitwise inverse of ph[10:1] when ph[11]=1.
- R6: With mode=10 or 11 (square), the sample is 1023 when ph[11]=1 and 0 otherwise.
- R7: While rst is high at an edge, the accumulator becomes 0, the sample becomes 512, and the square state (sq_out in both divider settings) becomes 0. Frequency and phase registers keep their contents, and rst takes priority over sleep.
- R8: While sleep is high and rst low at an edge, the accumulator, the sample, and the square state keep their values.
- R9: sq_out with sq_div2=0 is ph[11] as registered at the last active edge. With sq_div2=1, it toggles at each active edge where ph[11] is 1 and was 0 at the previous active edge.
- R10: The sample and sq_out after an active edge are computed from the accumulator value and selects present just before that edge, giving one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Freeze accumulator and outputs |
| fsel | input | 1 | Frequency word select |
| psel | input | 1 | Phase offset select |
| mode | input | 2 | 00 sine, 01 triangle, 1x square |
| sq_div2 | input | 1 | Divide square output by two |
| ld_f0 | input | 1 | Load freq word 0 from fword |
| ld_f1 | input | 1 | Load freq word 1 from fword |
| ld_p0 | input | 1 | Load offset 0 from pword |
| ld_p1 | input | 1 | Load offset 1 from pword |
| fword | input | 28 | Frequency load data |
| pword | input | 12 | Phase load data |
| sample | output | 10 | Unsigned waveform sample |
| sq_out | output | 1 | Square/clock output |

## Verification
Two pairs of events can land on the same edge. The first is reset and sleep: the bench raises both together mid-run and expects mid-scale output and a zeroed phase, since reset wins. The second is a rewrite of the tuning word that is currently selected, together with a select switch. The bench does this while the accumulator is running and expects the old increment for that edge and the new one from the next edge. A cycle-accurate model in the bench predicts sample and sq_out after every edge and compares them.

// File: rtl/dds_wavegen.sv
module dds_wavegen #(
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic             fsel,
  input  logic             psel,
  input  logic [1:0]       mode,
  input  logic             sq_div2,
  input  logic             ld_f0,
  input  logic             ld_f1,
  input  logic             ld_p0,
  input  logic             ld_p1,
  input  logic [ACC_W-1:0] fword,
  input  logic [11:0]      pword,
  output logic [9:0]       sample,
  output logic             sq_out
);
  localparam int PH_W  = 12;
  localparam int LUT_N = 1 << (PH_W - 4);
  localparam int HALF  = 2 * LUT_N;

  logic [ACC_W-1:0] f0_q, f1_q, acc_q;
  logic [PH_W-1:0]  p0_q, p1_q;
  logic [9:0]       samp_q, wave;
  logic             msb_q, tog_q;

  function automatic logic [8:0] quarter(input int p);
    int num, den;
    num = 511 * 4 * p * (HALF - p);
    den = (5 * HALF * HALF) / 4 - p * (HALF - p);
    return 9'(num / den);
  endfunction

  logic [8:0] lut [LUT_N];
  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    assign lut[g] = quarter(g);
  end

  wire [PH_W-1:0] ph  = acc_q[ACC_W-1 -: PH_W] + (psel ? p1_q : p0_q);
  wire [7:0]      idx = ph[10] ? ~ph[9:2] : ph[9:2];
  wire [9:0]      q   = {1'b0, lut[idx]};

  always_comb begin
    case (mode)
      2'b00:   wave = ph[11] ? (10'd511 - q) : (10'd512 + q);
      2'b01:   wave = ph[11] ? ~ph[10:1] : ph[10:1];
      default: wave = {10{ph[11]}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (ld_f0) f0_q <= fword;
    if (ld_f1) f1_q <= fword;
    if (ld_p0) p0_q <= pword;
    if (ld_p1) p1_q <= pword;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      samp_q <= 10'd512;
      msb_q  <= 1'b0;
      tog_q  <= 1'b0;
    end else if (!sleep) begin
      acc_q  <= acc_q + (fsel ? f1_q : f0_q);
      samp_q <= wave;
      msb_q  <= ph[11];
      tog_q  <= tog_q ^ (ph[11] & ~msb_q);
    end
  end

  assign sample = samp_q;
  assign sq_out = sq_div2 ? tog_q : msb_q;
endmodule

// File: rtl/dds_wavegen_chk.sv
module dds_wavegen_chk #(
  parameter int ACC_W = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep,
  input logic             fsel,
  input logic             ld_f0,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] f0,
  input logic [ACC_W-1:0] f1,
  input logic [9:0]       sample
);
  assert_acc_step_R1: assert property (@(posedge clk) disable iff (rst)
    !sleep |=> acc == ACC_W'($past(acc) + ($past(fsel) ? $past(f1) : $past(f0))));

  assert_freq_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ld_f0 |=> $stable(f0));

  assert_reset_state_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sample == 10'd512 && acc == '0));

  assert_sleep_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(sample) && $stable(acc)));
endmodule

bind dds_wavegen dds_wavegen_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .sleep(sleep), .fsel(fsel), .ld_f0(ld_f0),
  .acc(acc_q), .f0(f0_q), .f1(f1_q), .sample(samp_q)
);

// File: tb/sim_dds_wavegen.sv
module sim_dds_wavegen;
  logic clk = 0, rst = 1, sleep = 0, fsel = 0, psel = 0, sq_div2 = 0;
  logic ld_f0 = 0, ld_f1 = 0, ld_p0 = 0, ld_p1 = 0;
  logic [1:0]  mode = 0;
  logic [27:0] fword = 0;
  logic [11:0] pword = 0;
  logic [9:0]  sample;
  logic        sq_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dds_wavegen u0 (.*);

  logic [27:0] m_acc = 0, m_f0, m_f1;
  logic [11:0] m_p0, m_p1;
  logic [9:0]  m_samp = 512;
  logic        m_msb = 0, m_tog = 0;

  function automatic logic [9:0] ref_wave(input logic [11:0] ph, input logic [1:0] md);
    int i, qv;
    i  = ph[10] ? (255 - int'(ph[9:2])) : int'(ph[9:2]);
    qv = (511 * 4 * i * (512 - i)) / (327680 - i * (512 - i));
    if (md == 2'b00) return ph[11] ? 10'(511 - qv) : 10'(512 + qv);
    if (md == 2'b01) return ph[11] ? ~ph[10:1] : ph[10:1];
    return ph[11] ? 10'd1023 : 10'd0;
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    logic [11:0] ph;
    if (rst) begin
      m_acc = 0; m_samp = 512; m_msb = 0; m_tog = 0;
    end else if (!sleep) begin
      ph = m_acc[27:16] + (psel ? m_p1 : m_p0);
      m_samp = ref_wave(ph, mode);
      m_tog  = m_tog ^ (ph[11] & ~m_msb);
      m_msb  = ph[11];
      m_acc  = m_acc + (fsel ? m_f1 : m_f0);
    end
    if (ld_f0) m_f0 = fword;
    if (ld_f1) m_f1 = fword;
    if (ld_p0) m_p0 = pword;
    if (ld_p1) m_p1 = pword;
    @(posedge clk); #2;
    ld_f0 = 0; ld_f1 = 0; ld_p0 = 0; ld_p1 = 0;
    check({tag, " sample"}, sample, m_samp);
    check({tag, " sq_out"}, {9'd0, sq_out}, {9'd0, sq_div2 ? m_tog : m_msb});
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  // {phase offset, mode, expected sample}, frequency word zero
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {12'h000, 2'b00, 10'd512}, {12'h400, 2'b00, 10'd1022},
    {12'h3FC, 2'b00, 10'd1022}, {12'h200, 2'b00, 10'd872},
    {12'h600, 2'b00, 10'd870}, {12'h800, 2'b00, 10'd511},
    {12'hC00, 2'b00, 10'd1},   {12'h000, 2'b01, 10'd0},
    {12'h002, 2'b01, 10'd1},   {12'h7FE, 2'b01, 10'd1023},
    {12'h800, 2'b01, 10'd1023}, {12'hFFE, 2'b01, 10'd0},
    {12'h7FF, 2'b10, 10'd0},   {12'h800, 2'b11, 10'd1023}
  };

  initial begin
    #2;
    fword = 28'h0; ld_f0 = 1; tick("R7 load");
    fword = 28'h0030000; ld_f1 = 1; tick("R7 load");
    pword = 12'h000; ld_p0 = 1; tick("R7 load");
    pword = 12'h800; ld_p1 = 1; tick("R7 load");
    check("R7 reset sample", sample, 10'd512);
    check("R7 reset sq", {9'd0, sq_out}, 10'd0);
    rst = 0;
    for (int v = 0; v < NV; v++) begin
      pword = VEC[v][23:12]; mode = VEC[v][11:10]; ld_p0 = 1;
      tick("R3 vec");
      tick("R3 vec");
      check($sformatf("R4/R5/R6 vec %0d", v), sample, VEC[v][9:0]);
    end
    pword = 12'h000; ld_p0 = 1; mode = 2'b01; tick("R3");
    fword = 28'h0010000; ld_f0 = 1; tick("R2");
    run(40, "R1 R5 R10 triangle");
    fsel = 1; run(20, "R1 fsel switch");
    fsel = 0; run(5, "R1 fsel back");
    psel = 1; run(5, "R3 psel");
    psel = 0;
    fword = 28'h0050000; ld_f1 = 1; fsel = 1; tick("R2 load+switch");
    run(6, "R2 new word");
    fsel = 0;
    begin
      logic [9:0] held;
      held = sample;
      sleep = 1; fword = 28'h0020000; ld_f0 = 1;
      run(6, "R8 sleep");
      check("R8 held sample", sample, held);
      sleep = 0; run(10, "R8 wake R2");
    end
    mode = 2'b00; fword = 28'h0230000; ld_f0 = 1; run(40, "R4 sine");
    mode = 2'b10; run(20, "R6 square");
    fword = 28'h0800000; ld_f0 = 1; mode = 2'b01;
    sq_div2 = 1; run(100, "R9 div2");
    sq_div2 = 0; run(40, "R9 direct");
    rst = 1; sleep = 1; run(2, "R7 rst+sleep");
    check("R7 priority", sample, 10'd512);
    rst = 0; sleep = 0; run(20, "R7 regs kept");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule